// File: doc/BRIEF.md
# Enable-Line Session Mode Controller

This block runs the sessions of a serial storage peripheral. A host selects what the peripheral does with two control lines. An enable line wakes the block. A handshake line, sampled at the instant the enable rises, chooses the session. With the handshake low, the session stores data: received bytes go to a write buffer and the transmit line is held high. With the handshake high, the session takes commands: received bytes go to a command interface and the transmit line carries the command responder's output.

When the enable drops during a storage session, the block asks the buffer to drain and save its location pointers. It returns to standby only when that handshake completes. If the enable is raised again while the block is still busy (flushing, or in a command session after the enable dropped), the block aborts. It signals that the pending data must be discarded, and it ignores everything until the next clean rising edge of the enable. The serial input is an idle-low 8N1 line, oversampled sixteen times per bit. Any byte whose start bit arrives inside a settling window after activation is discarded. A power-good input holds the whole block in reset while it is low.

Top module: `sess_mode_ctrl`

## Requirements
- R1: A rising enable with the handshake low enters the storage session (`stor_act` = 1).
- R2: A rising enable with the handshake high enters the command session (`cmd_act` = 1). In that session `tx_out` follows `cmd_tx`.
- R3: The command session ends only when the enable and the handshake are both low. Enable low alone keeps it running.
- R4: A falling enable in a storage session raises `flush_req`. It stays high until `flush_done` is seen, and then the block enters standby with every session output low.
- R5: A rising enable while storing, flushing or in a command session pulses `discard` for one cycle and forces the inactive state. No byte is delivered until a later rising enable starts a fresh session.
- R6: The serial line idles low. The start bit is high, eight data bits follow LSB first with a data 1 sent as a low level, and the stop bit is low. A received byte appears on `wr_data` with a one-cycle `wr_valid` (storage) or on `cmd_data` with `cmd_valid` (command).
- R7: A stop bit found at the high level pulses `frame_err` and drops the byte. Reception resumes once the line returns low.
- R8: A byte whose start bit begins less than `SETTLE_US` microseconds after the session starts is discarded.
- R9: `tx_out` is high during a storage session and low outside any session.
- R10: While `pwr_ok` is low, all state is held in reset and every session output is low.
- R11: Storage bytes appear only on the write port, and command bytes only on the command port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok | input | 1 | Supply good; low holds the block in reset |
| en_in | input | 1 | Asynchronous enable line |
| hs_in | input | 1 | Asynchronous handshake line, chooses the session type |
| rx_in | input | 1 | Idle-low asynchronous serial input |
| cmd_tx | input | 1 | Response bit stream from the command responder |
| flush_done | input | 1 | Buffer drained and pointers saved |
| tx_out | output | 1 | Serial output line |
| stor_act | output | 1 | Storage session active |
| cmd_act | output | 1 | Command session active |
| flush_req | output | 1 | Request to drain the buffer and save the pointers |
| discard | output | 1 | One-cycle pulse: abandon the pending session's data |
| wr_valid | output | 1 | Byte valid for the write buffer |
| wr_data | output | DW | Byte for the write buffer |
| cmd_valid | output | 1 | Byte valid for the command interface |
| cmd_data | output | DW | Byte for the command interface |
| frame_err | output | 1 | One-cycle pulse: stop bit was not at the idle level |

## Verification
On every cycle the checker confirms these rules: the transmit level during storage and command sessions, that each delivered byte goes to the port of the active session, that the flush request holds until it is acknowledged, that the command session follows its exit rule, that an abort leaves the block inactive, and that power loss forces every output low. Only the bench scenarios can show that bit order and polarity rebuild the right byte values. They also show that early bytes are dropped during the settling window, that a bad stop bit is rejected and then recovered from, and that the block resumes after an abort only on a fresh enable edge.

// File: rtl/sess_pkg.sv
package sess_pkg;

    typedef enum logic [2:0] {
        ST_STANDBY,
        ST_STORE,
        ST_CMD,
        ST_FLUSH,
        ST_ABORT
    } sess_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP,
        RX_WAIT
    } rx_state_e;

    localparam int OSR = 16;

endpackage

// File: rtl/sess_sync.sv
module sess_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            s1 <= '0;
            q  <= '0;
        end else begin
            s1 <= d;
            q  <= s1;
        end
    end
endmodule

// File: rtl/sess_rx.sv
// Oversampling 8N1 receiver; line input is in conventional polarity (1 = idle).
module sess_rx
    import sess_pkg::*;
#(
    parameter int DIV = 4,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          arst_n,
    input  logic          run,
    input  logic          line,
    output logic          start_seen,
    output logic          byte_vld,
    output logic [DW-1:0] byte_out,
    output logic          frm_err
);
    localparam int DCW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam int BCW = (DW > 1) ? $clog2(DW) : 1;

    rx_state_e       st;
    logic [DCW-1:0]  dcnt;
    logic [3:0]      os;
    logic [BCW-1:0]  bcnt;
    logic [DW-1:0]   sh;
    logic            tick;

    assign tick     = (dcnt == DCW'(DIV - 1));
    assign byte_out = sh;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            st <= RX_IDLE; dcnt <= '0; os <= '0; bcnt <= '0; sh <= '0;
            byte_vld <= 1'b0; frm_err <= 1'b0; start_seen <= 1'b0;
        end else if (!run) begin
            st <= RX_IDLE; dcnt <= '0; os <= '0; bcnt <= '0;
            byte_vld <= 1'b0; frm_err <= 1'b0; start_seen <= 1'b0;
        end else begin
            byte_vld   <= 1'b0;
            frm_err    <= 1'b0;
            start_seen <= 1'b0;
            dcnt       <= tick ? '0 : dcnt + 1'b1;
            unique case (st)
                RX_IDLE: if (!line) begin
                    st <= RX_START; start_seen <= 1'b1;
                    dcnt <= '0; os <= '0;
                end
                RX_START: if (tick) begin
                    if (os == 4'd7) begin
                        os <= '0;
                        if (!line) begin st <= RX_DATA; bcnt <= '0; end
                        else st <= RX_IDLE;
                    end else os <= os + 1'b1;
                end
                RX_DATA: if (tick) begin
                    if (os == 4'd15) begin
                        os <= '0;
                        sh <= {line, sh[DW-1:1]};
                        if (bcnt == BCW'(DW - 1)) st <= RX_STOP;
                        else bcnt <= bcnt + 1'b1;
                    end else os <= os + 1'b1;
                end
                RX_STOP: if (tick) begin
                    if (os == 4'd15) begin
                        os <= '0;
                        if (line) begin byte_vld <= 1'b1; st <= RX_IDLE; end
                        else begin frm_err <= 1'b1; st <= RX_WAIT; end
                    end else os <= os + 1'b1;
                end
                RX_WAIT: if (line) st <= RX_IDLE;
                default: st <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sess_mode_ctrl.sv
module sess_mode_ctrl
    import sess_pkg::*;
#(
    parameter int CLK_HZ    = 125_000_000,
    parameter int BAUD      = 9600,
    parameter int SETTLE_US = 200,
    parameter int DW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_ok,
    input  logic          en_in,
    input  logic          hs_in,
    input  logic          rx_in,
    input  logic          cmd_tx,
    input  logic          flush_done,
    output logic          tx_out,
    output logic          stor_act,
    output logic          cmd_act,
    output logic          flush_req,
    output logic          discard,
    output logic          wr_valid,
    output logic [DW-1:0] wr_data,
    output logic          cmd_valid,
    output logic [DW-1:0] cmd_data,
    output logic          frame_err
);
    localparam int RAW_DIV    = CLK_HZ / (BAUD * OSR);
    localparam int DIV        = (RAW_DIV > 0) ? RAW_DIV : 1;
    localparam int SETTLE_CYC = (CLK_HZ / 1_000_000) * SETTLE_US;
    localparam int SCW        = $clog2(SETTLE_CYC + 1);

    logic        arst_n;
    logic        en_s, hs_s, rx_s, en_d;
    logic        en_rise, en_fall;
    logic        in_sess;
    sess_state_e st, nxt;
    logic [SCW-1:0] settle;
    logic        settled, early;
    logic        rx_start, rx_vld, rx_ferr;
    logic [DW-1:0] rx_byte;

    assign arst_n = rst_n & pwr_ok;

    sess_sync #(.W(3)) u_sync (
        .clk(clk), .arst_n(arst_n),
        .d({rx_in, hs_in, en_in}), .q({rx_s, hs_s, en_s})
    );

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) en_d <= 1'b0;
        else         en_d <= en_s;
    end

    assign en_rise = en_s & ~en_d;
    assign en_fall = ~en_s & en_d;

    // State register
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st <= ST_STANDBY;
        else         st <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = st;
        unique case (st)
            ST_STANDBY, ST_ABORT: if (en_rise) nxt = hs_s ? ST_CMD : ST_STORE;
            ST_STORE: begin
                if (en_rise)      nxt = ST_ABORT;
                else if (en_fall) nxt = ST_FLUSH;
            end
            ST_CMD: begin
                if (en_rise)            nxt = ST_ABORT;
                else if (!en_s && !hs_s) nxt = ST_STANDBY;
            end
            ST_FLUSH: begin
                if (en_rise)         nxt = ST_ABORT;
                else if (flush_done) nxt = ST_STANDBY;
            end
            default: nxt = ST_STANDBY;
        endcase
    end

    // Settling guard: counts from session entry; latches per start bit
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            settle <= '0;
            early  <= 1'b0;
        end else begin
            if (!in_sess)            settle <= '0;
            else if (!settled)       settle <= settle + 1'b1;
            if (rx_start)            early  <= ~settled;
        end
    end
    assign settled = (settle == SCW'(SETTLE_CYC));

    sess_rx #(.DIV(DIV), .DW(DW)) u_rx (
        .clk(clk), .arst_n(arst_n), .run(in_sess), .line(~rx_s),
        .start_seen(rx_start), .byte_vld(rx_vld), .byte_out(rx_byte),
        .frm_err(rx_ferr)
    );

    // Outputs
    always_comb begin
        stor_act  = 1'b0;
        cmd_act   = 1'b0;
        flush_req = 1'b0;
        discard   = 1'b0;
        tx_out    = 1'b0;
        in_sess   = 1'b0;
        unique case (st)
            ST_STORE: begin
                stor_act = 1'b1; tx_out = 1'b1; in_sess = 1'b1; discard = en_rise;
            end
            ST_CMD: begin
                cmd_act = 1'b1; tx_out = cmd_tx; in_sess = 1'b1; discard = en_rise;
            end
            ST_FLUSH: begin
                flush_req = 1'b1; discard = en_rise;
            end
            ST_STANDBY, ST_ABORT: ;
            default: ;
        endcase
        wr_valid  = rx_vld & stor_act & ~early;
        cmd_valid = rx_vld & cmd_act & ~early;
        frame_err = rx_ferr & in_sess;
    end

    assign wr_data  = rx_byte;
    assign cmd_data = rx_byte;

endmodule

// File: rtl/sess_mode_chk.sv
module sess_mode_chk (
    input logic clk,
    input logic rst_n,
    input logic arst_n,
    input logic pwr_ok,
    input logic en_s,
    input logic hs_s,
    input logic tx_out,
    input logic cmd_tx,
    input logic stor_act,
    input logic cmd_act,
    input logic flush_req,
    input logic flush_done,
    input logic discard,
    input logic wr_valid,
    input logic cmd_valid
);
    AST_STORE_TX_HIGH: assert property (@(posedge clk) disable iff (!arst_n)
        stor_act |-> tx_out); // R9
    AST_CMD_TX_PASS: assert property (@(posedge clk) disable iff (!arst_n)
        cmd_act |-> (tx_out == cmd_tx)); // R2
    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!arst_n)
        (cmd_act && !discard && (en_s || hs_s)) |=> cmd_act); // R3
    AST_CMD_EXIT: assert property (@(posedge clk) disable iff (!arst_n)
        (cmd_act && !en_s && !hs_s) |=> !cmd_act); // R3
    AST_FLUSH_WAIT: assert property (@(posedge clk) disable iff (!arst_n)
        (flush_req && !flush_done && !discard) |=> flush_req); // R4
    AST_FLUSH_END: assert property (@(posedge clk) disable iff (!arst_n)
        (flush_req && flush_done && !discard) |=> (!flush_req && !stor_act && !cmd_act)); // R4
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
        discard |=> (!stor_act && !cmd_act && !flush_req)); // R5
    AST_WR_IN_STORE: assert property (@(posedge clk) disable iff (!arst_n)
        wr_valid |-> stor_act); // R11
    AST_CMD_IN_CMD: assert property (@(posedge clk) disable iff (!arst_n)
        cmd_valid |-> cmd_act); // R11
    AST_PWR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_ok |-> (!stor_act && !cmd_act && !flush_req && !tx_out)); // R10
endmodule

bind sess_mode_ctrl sess_mode_chk u_chk (
    .clk(clk), .rst_n(rst_n), .arst_n(arst_n), .pwr_ok(pwr_ok),
    .en_s(en_s), .hs_s(hs_s), .tx_out(tx_out), .cmd_tx(cmd_tx),
    .stor_act(stor_act), .cmd_act(cmd_act), .flush_req(flush_req),
    .flush_done(flush_done), .discard(discard),
    .wr_valid(wr_valid), .cmd_valid(cmd_valid)
);

// File: tb/sim_sess_mode_ctrl.sv
`timescale 1ns/1ps
module sim_sess_mode_ctrl;
    localparam int BITC = 64; // 16 x DIV(4) cycles per bit

    logic clk = 0;
    logic rst_n = 0, pwr_ok = 1, en_in = 0, hs_in = 0, rx_in = 0;
    logic cmd_tx = 0, flush_done = 0;
    logic tx_out, stor_act, cmd_act, flush_req, discard;
    logic wr_valid, cmd_valid, frame_err;
    logic [7:0] wr_data, cmd_data;

    int n_chk = 0, n_err = 0;
    int ferr_cnt = 0, disc_cnt = 0;
    logic [7:0] wr_q[$];
    logic [7:0] cmd_q[$];

    always #4 clk = ~clk;

    sess_mode_ctrl #(.CLK_HZ(125_000_000), .BAUD(1_953_125), .SETTLE_US(4), .DW(8)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_ok(pwr_ok), .en_in(en_in), .hs_in(hs_in),
        .rx_in(rx_in), .cmd_tx(cmd_tx), .flush_done(flush_done), .tx_out(tx_out),
        .stor_act(stor_act), .cmd_act(cmd_act), .flush_req(flush_req),
        .discard(discard), .wr_valid(wr_valid), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .frame_err(frame_err)
    );

    always @(negedge clk) begin
        if (wr_valid)  wr_q.push_back(wr_data);
        if (cmd_valid) cmd_q.push_back(cmd_data);
        if (frame_err) ferr_cnt++;
        if (discard)   disc_cnt++;
    end

    // Expected transmit level: 1 = storage, 2 = command, else inactive
    function automatic int exp_tx(int mode, logic ctx);
        if (mode == 1) return 1;
        if (mode == 2) return int'(ctx);
        return 0;
    endfunction

    // Pin level for a data bit on the idle-low line
    function automatic logic pin_of(logic b);
        return ~b;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit good_stop);
        rx_in = 1'b1; cyc(BITC);
        for (int i = 0; i < 8; i++) begin
            rx_in = pin_of(b[i]); cyc(BITC);
        end
        rx_in = good_stop ? 1'b0 : 1'b1; cyc(BITC);
        rx_in = 1'b0; cyc(16);
    endtask

    task automatic activate(input logic hs);
        hs_in = hs; cyc(3);
        en_in = 1'b1; cyc(6);
    endtask

    task automatic finish_sim;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_sim();
    end

    initial begin
        logic [7:0] exp_b[6];
        int base, dc;
        void'($urandom(32'h5EED_0042));
        cyc(4); rst_n = 1; cyc(4);
        chk("R9 reset tx", int'(tx_out), exp_tx(0, cmd_tx));
        chk("R10 reset idle", int'({stor_act, cmd_act, flush_req}), 0);

        // R1 storage session
        activate(1'b0);
        chk("R1 storage entered", int'(stor_act), 1);
        chk("R9 storage tx high", int'(tx_out), exp_tx(1, cmd_tx));

        // R8 early byte is dropped
        send_byte(8'hA5, 1'b1);
        chk("R8 early byte dropped", wr_q.size(), 0);
        cyc(100);

        // R6 random bytes
        base = wr_q.size();
        for (int i = 0; i < 6; i++) begin
            exp_b[i] = 8'($urandom);
            send_byte(exp_b[i], 1'b1);
        end
        chk("R6 byte count", wr_q.size() - base, 6);
        for (int i = 0; i < 6; i++)
            if (base + i < wr_q.size()) chk("R6 byte value", int'(wr_q[base+i]), int'(exp_b[i]));
        chk("R11 no cmd bytes in storage", cmd_q.size(), 0);

        // R7 bad stop
        base = wr_q.size();
        send_byte(8'h3C, 1'b0);
        chk("R7 frame error flagged", ferr_cnt, 1);
        chk("R7 bad byte dropped", wr_q.size(), base);
        send_byte(8'h81, 1'b1);
        chk("R7 recovery count", wr_q.size(), base + 1);
        if (wr_q.size() > base) chk("R7 recovery value", int'(wr_q[base]), 8'h81);

        // R4 flush handshake
        en_in = 1'b0; cyc(6);
        chk("R4 flush requested", int'(flush_req), 1);
        chk("R4 storage left", int'(stor_act), 0);
        cyc(40);
        chk("R4 flush held", int'(flush_req), 1);
        flush_done = 1'b1; cyc(1); flush_done = 1'b0; cyc(1);
        chk("R4 standby after done", int'({stor_act, cmd_act, flush_req}), 0);
        chk("R9 standby tx low", int'(tx_out), exp_tx(0, cmd_tx));

        // R2 command session
        activate(1'b1);
        chk("R2 command entered", int'(cmd_act), 1);
        cmd_tx = 1'b1; cyc(1);
        chk("R2 tx follows high", int'(tx_out), exp_tx(2, cmd_tx));
        cmd_tx = 1'b0; cyc(1);
        chk("R2 tx follows low", int'(tx_out), exp_tx(2, cmd_tx));
        cyc(600);
        base = wr_q.size();
        send_byte(8'h5A, 1'b1);
        chk("R2 cmd byte count", cmd_q.size(), 1);
        if (cmd_q.size() > 0) chk("R2 cmd byte value", int'(cmd_q[0]), 8'h5A);
        chk("R11 no write in command", wr_q.size(), base);

        // R3 exit rule
        en_in = 1'b0; cyc(6);
        chk("R3 enable low alone keeps session", int'(cmd_act), 1);
        hs_in = 1'b0; cyc(6);
        chk("R3 both low exits", int'(cmd_act), 0);

        // R5 abort during flush
        activate(1'b0); cyc(600);
        en_in = 1'b0; cyc(6);
        chk("R5 flushing", int'(flush_req), 1);
        dc = disc_cnt;
        en_in = 1'b1; cyc(6);
        chk("R5 discard pulse", disc_cnt - dc, 1);
        chk("R5 forced inactive", int'({stor_act, cmd_act, flush_req}), 0);
        base = wr_q.size();
        send_byte(8'h77, 1'b1);
        chk("R5 byte ignored while aborted", wr_q.size(), base);
        en_in = 1'b0; cyc(6);
        activate(1'b0);
        chk("R5 resumes on fresh edge", int'(stor_act), 1);
        cyc(600);
        send_byte(8'hC3, 1'b1);
        chk("R5 resumed delivery", wr_q.size(), base + 1);
        en_in = 1'b0; cyc(6);
        flush_done = 1'b1; cyc(1); flush_done = 1'b0; cyc(2);

        // R5 abort from command session
        activate(1'b1);
        en_in = 1'b0; cyc(6);
        dc = disc_cnt;
        en_in = 1'b1; cyc(6);
        chk("R5 command abort pulse", disc_cnt - dc, 1);
        chk("R5 command abort inactive", int'(cmd_act), 0);
        en_in = 1'b0; hs_in = 1'b0; cyc(6);

        // R10 power loss
        activate(1'b0);
        pwr_ok = 1'b0; cyc(1);
        chk("R10 power loss idle", int'({stor_act, cmd_act, flush_req}), 0);
        chk("R10 power loss tx", int'(tx_out), 0);
        en_in = 1'b0; cyc(3); pwr_ok = 1'b1; cyc(6);
        chk("R10 stays idle after power", int'(stor_act), 0);

        finish_sim();
    end
endmodule